// File: doc/BRIEF.md
# Segment-Pooled Four-Tap Transmit Equalizer

This block is the digital model of a quarter-rate transmit feed-forward equalizer whose drive strength comes from a fixed pool of sixteen identical output segments. Every clock it accepts one word of four unit intervals (UIs), carried as a 4-bit high lane and a 4-bit low lane. For each UI it reports the signed level that the summed segments would put on the line. Each segment drives the symbol found at the cursor position it is assigned to. The sign of that symbol's level can be flipped per cursor.

A tap's weight is not a multiplier coefficient. It is the number of segments pointed at that cursor, out of sixteen. All segments always take part, so the sum of the tap magnitudes never changes when the taps are rebalanced. A layout bit chooses where the main cursor sits in the four-tap span. One layout has one leading tap and two trailing taps. The other has two leading taps and one trailing tap. Symbols are mapped either as two-level NRZ or as Gray-coded four-level PAM.

Top module: `seg_ffe_top`

## Requirements
- R1: While `rst` is high, and on the first output after it, every lane of `out_lvl` is 0. Reset configuration: every segment is on tap code 1, all tap signs are positive, and the layout is 0.
- R2: With `pam_mode`=0, a high-lane bit of 0 maps to level -3 and a bit of 1 maps to +3. The low lane has no effect on the output.
- R3: With `pam_mode`=1, the pair {high,low} maps as 00→-3, 01→-1, 11→+1, 10→+3.
- R4: Segment s takes its tap code k from `cfg_assign[2s+1:2s]`. With layout 0, codes 0, 1, 2 and 3 read the symbol at UI offset +1, 0, -1 and -2 from the output UI.
- R5: With layout 1, codes 0, 1, 2 and 3 read the symbol at UI offset +2, +1, 0 and -1, which moves the main cursor to the third code.
- R6: When `cfg_sign[k]` is 1, every segment on tap code k contributes the negated level.
- R7: Bit i of a word is UI i, and bit 0 is the earliest. Output lane i is the sum of all segment contributions for UI i of the word accepted two clock edges earlier. History and lookahead UIs come from the neighbouring words.
- R8: Configuration inputs are captured only at an edge where `cfg_load` is high. The new configuration is first used by the output registered at the following edge. At other times the configuration inputs have no effect.
- R9: With all signs positive and a stream of one constant symbol of level L, every lane reads 16·L for any segment assignment and either layout.
- R10: Every lane value is even and lies within ±48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one quarter-rate word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pam_mode | input | 1 | 1 = four-level Gray mapping, 0 = two-level mapping |
| in_msb | input | LANES | High lane bits, bit 0 earliest UI |
| in_lsb | input | LANES | Low lane bits, bit 0 earliest UI |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_assign | input | 2·SEGS | Tap code per segment, 2 bits each |
| cfg_sign | input | 4 | Inversion flag per tap code |
| cfg_layout | input | 1 | 0 = one leading / two trailing taps, 1 = two leading / one trailing |
| out_lvl | output | LANES·OUT_W | Signed level per UI, lane i at bits [i·OUT_W +: OUT_W] |

## Verification
Random words under the reset configuration isolate the symbol mapping, because only the main code is populated. Random segment assignments under each layout separate the five UI offsets and expose any misrouting across a word boundary. Random sign vectors separate the per-code inversion from the assignment. Constant-symbol streams must give the same result for every assignment, which tells a constant-drive pool apart from a weight error. A mid-stream reload, with random values on the configuration inputs at all other times, pins down the exact edge at which a new configuration applies and shows that an unstrobed input changes nothing.

// File: rtl/ffe_pkg.sv
package ffe_pkg;
  localparam int LVL_W = 3;
  localparam int TAP_N = 4;
  localparam int TAP_W = 2;
  localparam int HIST  = 2;
  localparam int LOOK  = 2;

  typedef logic signed [LVL_W-1:0] level_t;

  typedef enum logic {
    LAYOUT_ONE_LEAD = 1'b0,
    LAYOUT_TWO_LEAD = 1'b1
  } layout_e;

  function automatic level_t sym_to_level(input logic pam, input logic hi, input logic lo);
    level_t v;
    if (!pam) begin
      v = hi ? level_t'(3) : level_t'(-3);
    end else begin
      case ({hi, lo})
        2'b00:   v = level_t'(-3);
        2'b01:   v = level_t'(-1);
        2'b11:   v = level_t'(1);
        default: v = level_t'(3);
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/ffe_symbol_map.sv
module ffe_symbol_map
  import ffe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   pam_mode,
  input  logic [LANES-1:0]       hi_bits,
  input  logic [LANES-1:0]       lo_bits,
  output logic [LANES*LVL_W-1:0] levels
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign levels[i*LVL_W +: LVL_W] = sym_to_level(pam_mode, hi_bits[i], lo_bits[i]);
  end
endmodule

// File: rtl/ffe_seg_cfg.sv
module ffe_seg_cfg
  import ffe_pkg::*;
#(
  parameter int SEGS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [SEGS*TAP_W-1:0] assign_in,
  input  logic [TAP_N-1:0]      sign_in,
  input  logic                  layout_in,
  output logic [SEGS*TAP_W-1:0] assign_q,
  output logic [TAP_N-1:0]      sign_q,
  output layout_e               layout_q
);
  localparam logic [TAP_W-1:0] MAIN_CODE = TAP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      assign_q <= {SEGS{MAIN_CODE}};
      sign_q   <= '0;
      layout_q <= LAYOUT_ONE_LEAD;
    end else if (load) begin
      assign_q <= assign_in;
      sign_q   <= sign_in;
      layout_q <= layout_e'(layout_in);
    end
  end
endmodule

// File: rtl/ffe_window.sv
module ffe_window
  import ffe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [LANES*LVL_W-1:0]              in_lv,
  output logic [(LANES+HIST+LOOK)*LVL_W-1:0]  win
);
  localparam int WORD_W = LANES * LVL_W;

  logic [WORD_W-1:0] cur_q;
  logic [WORD_W-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      prv_q <= '0;
    end else begin
      cur_q <= in_lv;
      prv_q <= cur_q;
    end
  end

  for (genvar h = 0; h < HIST; h++) begin : g_hist
    assign win[h*LVL_W +: LVL_W] = prv_q[(LANES-HIST+h)*LVL_W +: LVL_W];
  end
  assign win[HIST*LVL_W +: WORD_W] = cur_q;
  for (genvar a = 0; a < LOOK; a++) begin : g_look
    assign win[(HIST+LANES+a)*LVL_W +: LVL_W] = in_lv[a*LVL_W +: LVL_W];
  end
endmodule

// File: rtl/ffe_lane_sum.sv
module ffe_lane_sum
  import ffe_pkg::*;
#(
  parameter int SEGS  = 16,
  parameter int LANES = 4,
  parameter int OUT_W = 7,
  parameter int LANE  = 0
) (
  input  logic [(LANES+HIST+LOOK)*LVL_W-1:0] win,
  input  logic [SEGS*TAP_W-1:0]              assign_q,
  input  logic [TAP_N-1:0]                   sign_q,
  input  layout_e                            layout_q,
  output logic signed [OUT_W-1:0]            sum
);
  localparam int BASE = HIST + LANE + 1;

  logic signed [OUT_W-1:0] contrib [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [TAP_W-1:0] code;
    level_t           pick;
    logic [OUT_W-1:0] ext;
    int               idx;
    assign code = assign_q[s*TAP_W +: TAP_W];
    always_comb begin
      idx  = BASE + int'(layout_q) - int'(code);
      pick = win[idx*LVL_W +: LVL_W];
      ext  = {{(OUT_W-LVL_W){pick[LVL_W-1]}}, pick};
      contrib[s] = sign_q[code] ? -$signed(ext) : $signed(ext);
    end
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < SEGS; s++) begin
      sum = sum + contrib[s];
    end
  end
endmodule

// File: rtl/seg_ffe_top.sv
module seg_ffe_top
  import ffe_pkg::*;
#(
  parameter  int SEGS  = 16,
  parameter  int LANES = 4,
  localparam int OUT_W = $clog2(3*SEGS+1) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pam_mode,
  input  logic [LANES-1:0]      in_msb,
  input  logic [LANES-1:0]      in_lsb,
  input  logic                  cfg_load,
  input  logic [SEGS*2-1:0]     cfg_assign,
  input  logic [3:0]            cfg_sign,
  input  logic                  cfg_layout,
  output logic [LANES*OUT_W-1:0] out_lvl
);
  localparam int WIN_N = LANES + HIST + LOOK;

  logic [LANES*LVL_W-1:0]  in_lv;
  logic [WIN_N*LVL_W-1:0]  win;
  logic [SEGS*TAP_W-1:0]   act_assign;
  logic [TAP_N-1:0]        act_sign;
  layout_e                 act_layout;
  logic [LANES*OUT_W-1:0]  sum_d;

  ffe_symbol_map #(.LANES(LANES)) u_map (
    .pam_mode (pam_mode),
    .hi_bits  (in_msb),
    .lo_bits  (in_lsb),
    .levels   (in_lv)
  );

  ffe_window #(.LANES(LANES)) u_win (
    .clk   (clk),
    .rst   (rst),
    .in_lv (in_lv),
    .win   (win)
  );

  ffe_seg_cfg #(.SEGS(SEGS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .assign_in (cfg_assign),
    .sign_in   (cfg_sign),
    .layout_in (cfg_layout),
    .assign_q  (act_assign),
    .sign_q    (act_sign),
    .layout_q  (act_layout)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [OUT_W-1:0] lane_sum;
    ffe_lane_sum #(.SEGS(SEGS), .LANES(LANES), .OUT_W(OUT_W), .LANE(i)) u_sum (
      .win      (win),
      .assign_q (act_assign),
      .sign_q   (act_sign),
      .layout_q (act_layout),
      .sum      (lane_sum)
    );
    assign sum_d[i*OUT_W +: OUT_W] = lane_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) out_lvl <= '0;
    else     out_lvl <= sum_d;
  end
endmodule

// File: rtl/ffe_chk.sv
module ffe_chk #(
  parameter int SEGS  = 16,
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_load,
  input logic [SEGS*2-1:0]      cfg_assign,
  input logic [3:0]             cfg_sign,
  input logic                   cfg_layout,
  input logic [SEGS*2-1:0]      act_assign,
  input logic [3:0]             act_sign,
  input logic                   act_layout,
  input logic [LANES*($clog2(3*SEGS+1)+1)-1:0] out_lvl
);
  localparam int OUT_W = $clog2(3*SEGS+1) + 1;
  localparam int LIM   = 3 * SEGS;

  logic [LANES-1:0] odd_lane;
  logic [LANES-1:0] over_lane;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      odd_lane[i]  = out_lvl[i*OUT_W];
      over_lane[i] = ($signed(out_lvl[i*OUT_W +: OUT_W]) > LIM) ||
                     ($signed(out_lvl[i*OUT_W +: OUT_W]) < -LIM);
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_lvl == '0));

  // R8
  cfg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (act_assign == $past(cfg_assign)) && (act_sign == $past(cfg_sign))
                 && (act_layout == $past(cfg_layout)));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(act_assign) && $stable(act_sign) && $stable(act_layout));

  // R10
  even_level_chk: assert property (@(posedge clk) disable iff (rst)
    odd_lane == '0);

  // R10
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    over_lane == '0);
endmodule

bind seg_ffe_top ffe_chk #(.SEGS(SEGS), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_load   (cfg_load),
  .cfg_assign (cfg_assign),
  .cfg_sign   (cfg_sign),
  .cfg_layout (cfg_layout),
  .act_assign (act_assign),
  .act_sign   (act_sign),
  .act_layout (act_layout),
  .out_lvl    (out_lvl)
);

// File: tb/sim_seg_ffe_top.sv
module sim_seg_ffe_top;
  localparam int SEGS  = 16;
  localparam int LANES = 4;
  localparam int OUT_W = $clog2(3*SEGS+1) + 1;
  localparam logic [SEGS*2-1:0] DEF_ASG = {SEGS{2'd1}};

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   pam_mode = 1'b0;
  logic [LANES-1:0]       in_msb = '0;
  logic [LANES-1:0]       in_lsb = '0;
  logic                   cfg_load = 1'b0;
  logic [SEGS*2-1:0]      cfg_assign = '0;
  logic [3:0]             cfg_sign = '0;
  logic                   cfg_layout = 1'b0;
  logic [LANES*OUT_W-1:0] out_lvl;

  int checks = 0;
  int errors = 0;
  int lvl [0:511];

  seg_ffe_top #(.SEGS(SEGS), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .pam_mode(pam_mode), .in_msb(in_msb), .in_lsb(in_lsb),
    .cfg_load(cfg_load), .cfg_assign(cfg_assign), .cfg_sign(cfg_sign),
    .cfg_layout(cfg_layout), .out_lvl(out_lvl)
  );

  always #2 clk = ~clk;

  function automatic int map_sym(bit pam, bit hi, bit lo);
    if (!pam) return hi ? 3 : -3;
    case ({hi, lo})
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int model(int u, logic [SEGS*2-1:0] asg, logic [3:0] sgn, bit lay);
    int s = 0;
    for (int g = 0; g < SEGS; g++) begin
      int k = int'(asg[2*g +: 2]);
      int v = lvl[u + 1 + int'(lay) - k];
      s += sgn[k] ? -v : v;
    end
    return s;
  endfunction

  function automatic int lane_val(int i);
    return int'($signed(out_lvl[i*OUT_W +: OUT_W]));
  endfunction

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_load(logic [SEGS*2-1:0] asg, logic [3:0] sgn, bit lay);
    @(negedge clk);
    cfg_assign = asg; cfg_sign = sgn; cfg_layout = lay; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Streams n words; config A is active, optionally reloaded with B at iteration sw.
  // pat: 0 random, 1 constant symbol {ch,cl}. cexp: if set, also check 16*level (R9).
  task automatic run_stream(int n, bit pam, int pat, bit ch, bit cl,
                            logic [SEGS*2-1:0] aa, logic [3:0] as, bit al,
                            int sw, logic [SEGS*2-1:0] ba, logic [3:0] bs, bit bl,
                            bit cexp, string tag);
    logic [LANES-1:0] wm [0:63];
    logic [LANES-1:0] wl [0:63];
    for (int j = 0; j < n; j++) begin
      if (pat == 0) begin
        wm[j] = LANES'($urandom); wl[j] = LANES'($urandom);
      end else begin
        wm[j] = {LANES{ch}}; wl[j] = {LANES{cl}};
      end
      for (int i = 0; i < LANES; i++) lvl[4*j+i] = map_sym(pam, wm[j][i], wl[j][i]);
    end
    for (int i = 0; i < LANES; i++) lvl[4*n+i] = map_sym(pam, 1'b0, 1'b0);
    pam_mode = pam;
    for (int it = 0; it <= n + 1; it++) begin
      @(negedge clk);
      if (it >= 3 && it - 2 <= n - 2) begin
        int jw = it - 2;
        bit useb = (sw >= 0) && (it - 1 > sw);
        for (int i = 0; i < LANES; i++) begin
          int got = lane_val(i);
          int exp = useb ? model(4*jw+i, ba, bs, bl) : model(4*jw+i, aa, as, al);
          check(got, exp, $sformatf("%s word %0d lane %0d", tag, jw, i));
          if (cexp) check(got, 16 * map_sym(pam, ch, cl), $sformatf("R9 word %0d lane %0d", jw, i));
          check(got % 2, 0, $sformatf("R10 even word %0d lane %0d", jw, i));
        end
      end
      if (it < n) begin
        in_msb = wm[it]; in_lsb = wl[it];
      end else begin
        in_msb = '0; in_lsb = '0;
      end
      if (it == sw) begin
        cfg_assign = ba; cfg_sign = bs; cfg_layout = bl; cfg_load = 1'b1;
      end else begin
        cfg_load = 1'b0;
        cfg_assign = {$urandom, $urandom}; cfg_sign = 4'($urandom); cfg_layout = 1'($urandom);
      end
    end
    cfg_load = 1'b0;
  endtask

  function automatic logic [SEGS*2-1:0] rand_asg();
    return {$urandom, $urandom};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    in_msb = 4'hF; in_lsb = 4'h5;
    repeat (3) @(negedge clk);
    for (int i = 0; i < LANES; i++) check(lane_val(i), 0, "R1 out zero in reset");
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) check(lane_val(i), 0, "R1 out zero after reset");
    // default configuration: all segments on main, positive, layout 0
    run_stream(20, 1'b0, 0, 0, 0, DEF_ASG, 4'h0, 1'b0, -1, '0, '0, 1'b0, 1'b0, "R1 default cfg R2 nrz");
  endtask

  task automatic t_nrz();
    logic [SEGS*2-1:0] a = rand_asg();
    do_load(a, 4'h0, 1'b0);
    run_stream(30, 1'b0, 0, 0, 0, a, 4'h0, 1'b0, -1, '0, '0, 1'b0, 1'b0, "R2 R4 nrz layout0");
  endtask

  task automatic t_pam();
    logic [SEGS*2-1:0] a;
    do_load(DEF_ASG, 4'h0, 1'b0);
    run_stream(20, 1'b1, 0, 0, 0, DEF_ASG, 4'h0, 1'b0, -1, '0, '0, 1'b0, 1'b0, "R3 pam mapping");
    a = rand_asg();
    do_load(a, 4'h0, 1'b0);
    run_stream(30, 1'b1, 0, 0, 0, a, 4'h0, 1'b0, -1, '0, '0, 1'b0, 1'b0, "R4 R7 pam layout0");
  endtask

  task automatic t_layout1();
    logic [SEGS*2-1:0] a = rand_asg();
    do_load(a, 4'h0, 1'b1);
    run_stream(30, 1'b1, 0, 0, 0, a, 4'h0, 1'b1, -1, '0, '0, 1'b0, 1'b0, "R5 R7 layout1");
  endtask

  task automatic t_signs();
    for (int r = 0; r < 3; r++) begin
      logic [SEGS*2-1:0] a = rand_asg();
      logic [3:0] s = 4'($urandom);
      bit l = 1'($urandom);
      do_load(a, s, l);
      run_stream(24, 1'b1, 0, 0, 0, a, s, l, -1, '0, '0, 1'b0, 1'b0, "R6 signs");
    end
  endtask

  task automatic t_const();
    for (int c = 0; c < 4; c++) begin
      logic [SEGS*2-1:0] a = rand_asg();
      bit l = c[0];
      do_load(a, 4'h0, l);
      run_stream(8, 1'b1, 1, c[1], c[0], a, 4'h0, l, -1, '0, '0, 1'b0, 1'b1, "R9 const");
    end
  endtask

  task automatic t_switch();
    logic [SEGS*2-1:0] a = rand_asg();
    logic [SEGS*2-1:0] b = rand_asg();
    do_load(a, 4'h3, 1'b0);
    run_stream(24, 1'b1, 0, 0, 0, a, 4'h3, 1'b0, 10, b, 4'hA, 1'b1, 1'b0, "R8 reload edge");
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_nrz();
    t_pam();
    t_layout1();
    t_signs();
    t_const();
    t_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule